// File: doc/BRIEF.md
# SPI Configuration Load Sequencer

This block is the master side of a configuration loader for a target device that takes its configuration image over SPI. On a start pulse it runs a fixed command script over an SPI master port that it drives itself: it identifies the device, checks the identity against two accepted values, and prepares the device for writing. It then polls the device status until the configuration memory reports cleared, streams the whole image inside one chip-select frame, closes writing and reads the status once more to see whether the device reports done.

The image arrives on a byte stream with a valid/ready handshake. Its length in bytes is given on `bit_len` at the start pulse. The block pulls bytes only while it is sending the data part of the image frame. At the end of a run it drops `busy`, and it either raises `success` or reports a coded error. Both results stay in place until the next accepted start.

The control state machine has these states: IDLE, IDENT (read ID), STAT0 (first status read), REFRESH, WREN (write enable), CLEAR, POLL (status read), WAIT (poll interval), STREAM (image frame), WRDIS (write disable) and FINAL (last status read). The transitions are:
- IDLE→IDENT on a start with a non-zero length.
- IDENT→STAT0 on an accepted ID, or IDENT→IDLE with the bad-ID error.
- STAT0→REFRESH→WREN→CLEAR→POLL, each step taken when the current frame completes.
- POLL→STREAM on the cleared word.
- POLL→WAIT when the status is not cleared and attempts remain.
- POLL→IDLE with the timeout error when no attempts remain.
- WAIT→POLL when the interval timer expires.
- STREAM→WRDIS→FINAL→IDLE, with the result set on the last step.

Top module: `cfg_load_seq`

## Requirements
- R1: SPI uses mode 0, and every byte is sent most significant bit first. A command frame is 4 bytes long: the opcode and then three 0x00 bytes. A read frame is 8 bytes long: the opcode, three 0x00 bytes, then four bytes clocked in from `spi_miso` and packed first-byte-most-significant into a 32-bit word.
- R2: A full run sends its frames in this order, with these opcodes: 0x07 (read ID), 0x09 (read status), 0x71 (refresh), 0x4A (write enable), 0x70 (clear), one or more 0x09 status polls, 0x41 (image frame), 0x4F (write disable), 0x09 (final read status).
- R3: Only the ID words 0xC2088080 and 0xC2048080 are accepted. Any other ID ends the run with `err_code`=2 after the ID frame, and no other frame is sent.
- R4: A poll counts as cleared only if the status word is exactly 0x00010000. A word that has other bits set as well is treated as not cleared.
- R5: At most POLL_MAX polls are made. Consecutive polls start at least POLL_MS×CYC_PER_MS clock cycles plus one read-frame time apart. When the attempts run out, the run ends with `err_code`=3 and no image frame is sent.
- R6: The image frame is sent under one chip-select assertion. It holds 0x41, then 0xFF 0xFF 0xFF, then exactly `bit_len` stream bytes in arrival order, then four 0x00 bytes. `bs_ready` is high only during the data part of this frame.
- R7: A start with `bit_len`=0 sends no frame, keeps `busy` low, and sets `err_code`=1 on the next cycle.
- R8: `success`=1 with `err_code`=0 only if bit 14 (mask 0x00004000) is set in the final status word. If that bit is clear, `err_code`=4.
- R9: Chip select goes high for at least 2×CLK_DIV clock cycles between frames, and `spi_sclk` stays low while chip select is high.
- R10: `busy` is high for the whole run. A start while busy is ignored. `err_code` and `success` hold their values while idle until the next start.
- R11: When the device reports cleared on the last allowed poll, the image is still streamed, and the timeout is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled when idle |
| bit_len | input | LEN_W | Image length in bytes, sampled with start |
| bs_data | input | 8 | Image byte |
| bs_valid | input | 1 | Image byte valid |
| bs_ready | output | 1 | Image byte taken when high with bs_valid |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to device |
| spi_miso | input | 1 | SPI data from device |
| busy | output | 1 | Run in progress |
| success | output | 1 | Last run configured the device |
| err_code | output | 3 | 0 none, 1 zero length, 2 bad ID, 3 clear timeout, 4 done flag missing |

## Verification
Two decisions can fall on the same poll result: the detection of the cleared word and the exhaustion of the attempt budget. The bench provokes this by having the device model report cleared on exactly attempt POLL_MAX. The run must then go on to the image frame and end in success, not in the timeout error. A second case has a status word that includes the cleared bit but has other bits set, held until the budget runs out. That run must time out, which separates the exact-match rule from a bit test.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_IDENT, ST_STAT0, ST_REFRESH, ST_WREN, ST_CLEAR,
        ST_POLL, ST_WAIT, ST_STREAM, ST_WRDIS, ST_FINAL
    } seq_state_t;

    typedef enum logic [1:0] {FK_CMD, FK_READ, FK_STREAM} frame_kind_t;

    typedef enum logic [1:0] {FS_IDLE, FS_LOAD, FS_SHIFT, FS_GAP} frame_state_t;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0, ERR_ZLEN = 3'd1, ERR_BADID = 3'd2,
        ERR_TMO = 3'd3, ERR_NODONE = 3'd4
    } err_t;

    localparam logic [7:0] OP_RD_ID   = 8'h07;
    localparam logic [7:0] OP_RD_STAT = 8'h09;
    localparam logic [7:0] OP_CLEAR   = 8'h70;
    localparam logic [7:0] OP_REFRESH = 8'h71;
    localparam logic [7:0] OP_WR_EN   = 8'h4A;
    localparam logic [7:0] OP_WR_DIS  = 8'h4F;
    localparam logic [7:0] OP_WR_INC  = 8'h41;

    localparam logic [31:0] DEV_ID_A     = 32'hC208_8080;
    localparam logic [31:0] DEV_ID_B     = 32'hC204_8080;
    localparam logic [31:0] STAT_CLEARED = 32'h0001_0000;
    localparam logic [31:0] STAT_DONE    = 32'h0000_4000;

endpackage

// File: rtl/cfg_spi_byte.sv
module cfg_spi_byte #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic          active;
    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;
    logic          sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    tx_sh   <= tx_byte;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                    sclk_q  <= 1'b0;
                end
            end else if (div_cnt == DW'(CLK_DIV - 1)) begin
                div_cnt <= '0;
                sclk_q  <= !sclk_q;
                if (!sclk_q) begin
                    // rising edge: sample the device
                    rx_sh <= {rx_sh[6:0], miso};
                end else if (bit_cnt == 3'd7) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    // falling edge: present next bit
                    bit_cnt <= bit_cnt + 3'd1;
                    tx_sh   <= {tx_sh[6:0], 1'b0};
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = active & tx_sh[7];
    assign rx_byte = rx_sh;

endmodule

// File: rtl/cfg_frame.sv
module cfg_frame
    import cfg_load_pkg::*;
#(
    parameter int LEN_W   = 24,
    parameter int CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  frame_kind_t      kind,
    input  logic [7:0]       opcode,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       bs_data,
    input  logic             bs_valid,
    output logic             bs_ready,
    output logic             eng_go,
    output logic [7:0]       eng_tx,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx,
    output logic             cs_n,
    output logic             done,
    output logic [31:0]      rx_word
);
    localparam int IW  = LEN_W + 1;
    localparam int GAP = 2 * CLK_DIV;
    localparam int GW  = $clog2(GAP + 1);

    frame_state_t     fst;
    frame_kind_t      k_q;
    logic [7:0]       op_q;
    logic [LEN_W-1:0] len_q;
    logic [IW-1:0]    idx;
    logic [GW-1:0]    gcnt;
    logic [IW-1:0]    last_idx;
    logic [IW-1:0]    data_end;
    logic             need_data;

    always_comb begin
        data_end  = {1'b0, len_q} + IW'(4);
        need_data = (k_q == FK_STREAM) && (idx >= IW'(4)) && (idx < data_end);
        unique case (k_q)
            FK_READ:   last_idx = IW'(7);
            FK_STREAM: last_idx = {1'b0, len_q} + IW'(7);
            default:   last_idx = IW'(3);
        endcase
        if (idx == '0)            eng_tx = op_q;
        else if (idx < IW'(4))    eng_tx = (k_q == FK_STREAM) ? 8'hFF : 8'h00;
        else if (need_data)       eng_tx = bs_data;
        else                      eng_tx = 8'h00;
    end

    assign bs_ready = (fst == FS_LOAD) && need_data;
    assign eng_go   = (fst == FS_LOAD) && (!need_data || bs_valid);
    assign cs_n     = (fst == FS_IDLE) || (fst == FS_GAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fst     <= FS_IDLE;
            k_q     <= FK_CMD;
            op_q    <= '0;
            len_q   <= '0;
            idx     <= '0;
            gcnt    <= '0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            unique case (fst)
                FS_IDLE: if (start) begin
                    k_q     <= kind;
                    op_q    <= opcode;
                    len_q   <= len;
                    idx     <= '0;
                    rx_word <= '0;
                    fst     <= FS_LOAD;
                end
                FS_LOAD: if (eng_go) fst <= FS_SHIFT;
                FS_SHIFT: if (eng_done) begin
                    if (k_q == FK_READ && idx >= IW'(4))
                        rx_word <= {rx_word[23:0], eng_rx};
                    if (idx == last_idx) begin
                        gcnt <= '0;
                        fst  <= FS_GAP;
                    end else begin
                        idx <= idx + IW'(1);
                        fst <= FS_LOAD;
                    end
                end
                FS_GAP: if (gcnt == GW'(GAP - 1)) begin
                    fst  <= FS_IDLE;
                    done <= 1'b1;
                end else begin
                    gcnt <= gcnt + GW'(1);
                end
            endcase
        end
    end

endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
    parameter int TICKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int TW = $clog2(TICKS + 1);

    logic          running;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (start) begin
                running <= 1'b1;
                cnt     <= TW'(TICKS - 1);
            end else if (running) begin
                if (cnt == '0) begin
                    running <= 1'b0;
                    expire  <= 1'b1;
                end else begin
                    cnt <= cnt - TW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int CLK_DIV    = 4,
    parameter int CYC_PER_MS = 50000,
    parameter int POLL_MS    = 10,
    parameter int POLL_MAX   = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] bit_len,
    input  logic [7:0]       bs_data,
    input  logic             bs_valid,
    output logic             bs_ready,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             busy,
    output logic             success,
    output logic [2:0]       err_code
);
    localparam int PW    = $clog2(POLL_MAX + 1);
    localparam int TICKS = CYC_PER_MS * POLL_MS;

    seq_state_t       st, st_n;
    err_t             fail_code;
    logic             finish;
    logic [PW-1:0]    polls;
    logic [LEN_W-1:0] len_q;
    logic             fr_start, fr_done;
    frame_kind_t      fr_kind;
    logic [7:0]       fr_op;
    logic [31:0]      fr_rx;
    logic             eng_go, eng_done;
    logic [7:0]       eng_tx, eng_rx;
    logic             tm_start, tm_expire;
    logic             id_ok, last_try;

    assign id_ok    = (fr_rx == DEV_ID_A) || (fr_rx == DEV_ID_B);
    assign last_try = (32'(polls) + 32'd1) >= 32'(POLL_MAX);

    // next-state
    always_comb begin
        st_n      = st;
        finish    = 1'b0;
        fail_code = ERR_NONE;
        unique case (st)
            ST_IDLE:    if (start && bit_len != '0) st_n = ST_IDENT;
            ST_IDENT:   if (fr_done) begin
                            if (id_ok) st_n = ST_STAT0;
                            else begin
                                st_n = ST_IDLE; finish = 1'b1; fail_code = ERR_BADID;
                            end
                        end
            ST_STAT0:   if (fr_done) st_n = ST_REFRESH;
            ST_REFRESH: if (fr_done) st_n = ST_WREN;
            ST_WREN:    if (fr_done) st_n = ST_CLEAR;
            ST_CLEAR:   if (fr_done) st_n = ST_POLL;
            ST_POLL:    if (fr_done) begin
                            if (fr_rx == STAT_CLEARED) st_n = ST_STREAM;
                            else if (last_try) begin
                                st_n = ST_IDLE; finish = 1'b1; fail_code = ERR_TMO;
                            end else st_n = ST_WAIT;
                        end
            ST_WAIT:    if (tm_expire) st_n = ST_POLL;
            ST_STREAM:  if (fr_done) st_n = ST_WRDIS;
            ST_WRDIS:   if (fr_done) st_n = ST_FINAL;
            ST_FINAL:   if (fr_done) begin
                            st_n = ST_IDLE; finish = 1'b1;
                            fail_code = ((fr_rx & STAT_DONE) != '0) ? ERR_NONE : ERR_NODONE;
                        end
        endcase
    end

    // frame selection for the state being entered
    always_comb begin
        unique case (st_n)
            ST_IDENT:                      begin fr_kind = FK_READ;   fr_op = OP_RD_ID;   end
            ST_STAT0, ST_POLL, ST_FINAL:   begin fr_kind = FK_READ;   fr_op = OP_RD_STAT; end
            ST_REFRESH:                    begin fr_kind = FK_CMD;    fr_op = OP_REFRESH; end
            ST_WREN:                       begin fr_kind = FK_CMD;    fr_op = OP_WR_EN;   end
            ST_CLEAR:                      begin fr_kind = FK_CMD;    fr_op = OP_CLEAR;   end
            ST_STREAM:                     begin fr_kind = FK_STREAM; fr_op = OP_WR_INC;  end
            ST_WRDIS:                      begin fr_kind = FK_CMD;    fr_op = OP_WR_DIS;  end
            default:                       begin fr_kind = FK_CMD;    fr_op = 8'h00;      end
        endcase
        fr_start = (st_n != st) && (st_n != ST_IDLE) && (st_n != ST_WAIT);
        tm_start = (st_n == ST_WAIT) && (st != ST_WAIT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // outputs and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            success  <= 1'b0;
            err_code <= ERR_NONE;
            polls    <= '0;
            len_q    <= '0;
        end else begin
            busy <= (st_n != ST_IDLE);
            if (st == ST_IDLE && start) begin
                success  <= 1'b0;
                err_code <= (bit_len == '0) ? ERR_ZLEN : ERR_NONE;
                polls    <= '0;
                len_q    <= bit_len;
            end
            if (st == ST_POLL && fr_done) polls <= polls + PW'(1);
            if (finish) begin
                err_code <= fail_code;
                success  <= (fail_code == ERR_NONE);
            end
        end
    end

    cfg_frame #(.LEN_W(LEN_W), .CLK_DIV(CLK_DIV)) frame_i (
        .clk(clk), .rst_n(rst_n), .start(fr_start), .kind(fr_kind),
        .opcode(fr_op), .len(len_q), .bs_data(bs_data), .bs_valid(bs_valid),
        .bs_ready(bs_ready), .eng_go(eng_go), .eng_tx(eng_tx),
        .eng_done(eng_done), .eng_rx(eng_rx), .cs_n(spi_cs_n),
        .done(fr_done), .rx_word(fr_rx)
    );

    cfg_spi_byte #(.CLK_DIV(CLK_DIV)) spi_i (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .tx_byte(eng_tx),
        .done(eng_done), .rx_byte(eng_rx), .sclk(spi_sclk),
        .mosi(spi_mosi), .miso(spi_miso)
    );

    cfg_poll_timer #(.TICKS(TICKS)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(tm_start), .expire(tm_expire)
    );

endmodule

// File: rtl/cfg_load_seq_chk.sv
module cfg_load_seq_chk #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] bit_len,
    input logic             bs_ready,
    input logic             spi_sclk,
    input logic             spi_cs_n,
    input logic             busy,
    input logic             success,
    input logic [2:0]       err_code
);
    p_cs_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    p_ready_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bs_ready |-> (!spi_cs_n && busy));

    p_sclk_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    p_ok_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> (err_code == 3'd0));

    p_code_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_code <= 3'd4);

    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(err_code) && $stable(success)));

    p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bit_len == '0) |=> (err_code == 3'd1 && !busy));

endmodule

bind cfg_load_seq cfg_load_seq_chk #(.LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_len(bit_len),
    .bs_ready(bs_ready), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .busy(busy), .success(success), .err_code(err_code)
);

// File: tb/cfg_load_seq_tb_top.sv
module cfg_load_seq_tb_top;
    localparam int LEN_W      = 16;
    localparam int CLK_DIV    = 2;
    localparam int CYC_PER_MS = 3;
    localparam int POLL_MS    = 10;
    localparam int POLL_MAX   = 6;
    localparam int READ_CYC   = 64 * 2 * CLK_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] bit_len = '0;
    logic [7:0] bs_data = '0;
    logic bs_valid = 1'b0;
    logic bs_ready, spi_sclk, spi_cs_n, spi_mosi, spi_miso, busy, success;
    logic [2:0] err_code;

    always #10 clk = ~clk;

    cfg_load_seq #(.LEN_W(LEN_W), .CLK_DIV(CLK_DIV), .CYC_PER_MS(CYC_PER_MS),
                   .POLL_MS(POLL_MS), .POLL_MAX(POLL_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_len(bit_len),
        .bs_data(bs_data), .bs_valid(bs_valid), .bs_ready(bs_ready),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .busy(busy), .success(success), .err_code(err_code)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(negedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    // ---------------- device model ----------------
    logic [31:0] m_id, m_notclr, m_final;
    int m_k;
    logic [31:0] resp_w = '0;
    logic [7:0] fbytes [0:31];
    logic [7:0] cur_sh = '0;
    logic [7:0] ops [0:31];
    int nbits = 0, fc = 0, nframes = 0, poll_idx = 0;
    bit clr_seen = 0, wrdis_seen = 0, stream_seen = 0, had_frame = 0;
    int fmt_bad = 0, gap_bad = 0, rdy_bad = 0, spacing_bad = 0;
    int fall_cyc = 0, last_end = 0, prev_poll = -1, exp_len = 0;

    function automatic logic miso_bit(input int f, input logic [31:0] w);
        logic [4:0] bi;
        if (f < 32 || f >= 64) return 1'b0;
        bi = 5'(63 - f);
        return w[bi];
    endfunction

    assign spi_miso = (!spi_cs_n) ? miso_bit(fc, resp_w) : 1'b0;

    always @(negedge spi_cs_n) begin
        nbits = 0; fc = 0; fall_cyc = cyc;
        if (had_frame && (cyc - last_end) < 2 * CLK_DIV) gap_bad++;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        cur_sh = {cur_sh[6:0], spi_mosi};
        nbits++;
        if (nbits % 8 == 0 && nbits / 8 <= 32) fbytes[nbits/8 - 1] = cur_sh;
        if (nbits == 8) begin
            if (cur_sh == 8'h07) resp_w = m_id;
            else if (cur_sh == 8'h09) begin
                if (!clr_seen) resp_w = 32'h0;
                else if (wrdis_seen) resp_w = m_final;
                else begin
                    resp_w = (poll_idx >= m_k) ? 32'h0001_0000 : m_notclr;
                    poll_idx++;
                end
            end else resp_w = 32'h0;
        end
    end

    always @(negedge spi_sclk) if (!spi_cs_n) fc++;

    always @(posedge spi_cs_n) if (nbits > 0) begin
        automatic int nb = nbits / 8;
        automatic logic [7:0] op = fbytes[0];
        had_frame = 1; last_end = cyc;
        if (nframes < 32) ops[nframes] = op;
        nframes++;
        if (nbits % 8 != 0) fmt_bad++;
        if (op == 8'h41) begin                              // R6 frame layout
            stream_seen = 1;
            if (nb != exp_len + 8) fmt_bad++;
            for (int i = 1; i < 4; i++) if (fbytes[i] != 8'hFF) fmt_bad++;
            for (int i = 0; i < exp_len; i++) if (fbytes[4+i] != pat(i)) fmt_bad++;
            for (int i = 0; i < 4; i++) if (fbytes[4+exp_len+i] != 8'h00) fmt_bad++;
        end else begin                                      // R1 frame layout
            if (nb != ((op == 8'h07 || op == 8'h09) ? 8 : 4)) fmt_bad++;
            for (int i = 1; i < 4; i++) if (fbytes[i] != 8'h00) fmt_bad++;
            if (op == 8'h70) clr_seen = 1;
            if (op == 8'h4F) wrdis_seen = 1;
            if (op == 8'h09 && clr_seen && !stream_seen) begin   // R5 spacing
                if (prev_poll >= 0 && (fall_cyc - prev_poll) < READ_CYC + POLL_MS * CYC_PER_MS)
                    spacing_bad++;
                prev_poll = fall_cyc;
            end
        end
    end

    // ---------------- image source ----------------
    int took = 0;
    bit feed_on = 0;
    always @(posedge clk) if (bs_valid && bs_ready) took <= took + 1;
    always @(negedge clk) begin
        bs_valid <= feed_on && (took < exp_len) && (cyc % 5 != 2);
        bs_data  <= pat(took);
        if (bs_ready && (spi_cs_n || ops_cur() != 8'h41)) rdy_bad++;
    end
    function automatic logic [7:0] ops_cur();
        return fbytes[0];
    endfunction

    // ---------------- run helpers ----------------
    task automatic pulse_start(input int len);
        @(negedge clk); bit_len = LEN_W'(len); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic clear_model(input logic [31:0] id, input int k,
                               input logic [31:0] notclr, input logic [31:0] fin, input int len);
        m_id = id; m_k = k; m_notclr = notclr; m_final = fin; exp_len = len;
        nframes = 0; poll_idx = 0; clr_seen = 0; wrdis_seen = 0; stream_seen = 0;
        fmt_bad = 0; gap_bad = 0; rdy_bad = 0; spacing_bad = 0; prev_poll = -1;
        had_frame = 0; fbytes[0] = 8'h00;
        @(negedge clk); took = 0; feed_on = 1;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        feed_on = 0;
    endtask

    // mode 0 full run, 1 bad id, 2 timeout
    task automatic check_ops(input string req, input int mode, input int k);
        logic [7:0] e [0:31];
        int n = 0;
        e[n++] = 8'h07;
        if (mode != 1) begin
            e[n++] = 8'h09; e[n++] = 8'h71; e[n++] = 8'h4A; e[n++] = 8'h70;
            for (int i = 0; i < ((mode == 2) ? POLL_MAX : k + 1); i++) e[n++] = 8'h09;
            if (mode == 0) begin e[n++] = 8'h41; e[n++] = 8'h4F; e[n++] = 8'h09; end
        end
        chk(nframes == n, {req, " frame count"}, nframes, n);
        for (int i = 0; i < n && i < nframes; i++)
            chk(ops[i] == e[i], {req, " opcode order"}, ops[i], e[i]);
        chk(fmt_bad == 0, "R1/R6 frame format", fmt_bad, 0);
        chk(gap_bad == 0, "R9 chip-select gap", gap_bad, 0);
        chk(rdy_bad == 0, "R6 ready window", rdy_bad, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !success && err_code == 0, "R10 reset outputs", {busy, success, err_code}, 0);
        chk(spi_cs_n && !spi_sclk && !bs_ready, "R9 reset bus idle", {spi_cs_n, spi_sclk, bs_ready}, 3'b100);
    endtask

    task automatic t_zero_len();
        clear_model(32'hC208_8080, 0, 0, 32'h4000, 0);
        pulse_start(0);
        chk(err_code == 3'd1 && !busy, "R7 zero length", err_code, 1);
        repeat (20) @(negedge clk);
        chk(nframes == 0, "R7 no frame", nframes, 0);
        chk(err_code == 3'd1 && !success, "R10 result held", err_code, 1);
        feed_on = 0;
    endtask

    task automatic t_bad_id(input logic [31:0] id);
        clear_model(id, 0, 0, 32'h4000, 4);
        pulse_start(4);
        wait_idle();
        chk(err_code == 3'd2 && !success, "R3 bad id code", err_code, 2);
        check_ops("R3", 1, 0);
        chk(took == 0, "R3 no image taken", took, 0);
    endtask

    task automatic t_good_a();
        clear_model(32'hC208_8080, 2, 32'h0, 32'h0000_4000, 6);
        pulse_start(6);
        repeat (60) @(negedge clk);
        pulse_start(0);                                   // R10 ignored while busy
        wait_idle();
        chk(success && err_code == 0, "R8 success", {success, err_code}, 4'b1000);
        check_ops("R2", 0, 2);
        chk(took == 6, "R6 bytes taken", took, 6);
        chk(spacing_bad == 0, "R5 poll spacing", spacing_bad, 0);
        repeat (10) @(negedge clk);
        chk(success && err_code == 0, "R10 result held idle", {success, err_code}, 4'b1000);
    endtask

    task automatic t_no_done();
        clear_model(32'hC204_8080, 0, 32'h0, 32'hFFFF_BFFF, 3);
        pulse_start(3);
        wait_idle();
        chk(!success && err_code == 3'd4, "R8 done missing", err_code, 4);
        check_ops("R2 alt id", 0, 0);
        chk(took == 3, "R6 bytes taken", took, 3);
    endtask

    task automatic t_timeout();
        clear_model(32'hC208_8080, 1000, 32'h0001_4000, 32'h4000, 5);
        pulse_start(5);
        wait_idle();
        chk(!success && err_code == 3'd3, "R4/R5 timeout code", err_code, 3);
        check_ops("R5", 2, 0);
        chk(!stream_seen && took == 0, "R5 no image frame", took, 0);
        chk(spacing_bad == 0, "R5 poll spacing", spacing_bad, 0);
    endtask

    task automatic t_last_try();
        clear_model(32'hC208_8080, POLL_MAX - 1, 32'h0, 32'h0000_C000, 2);
        pulse_start(2);
        wait_idle();
        chk(success && err_code == 0, "R11 clear on last poll", err_code, 0);
        check_ops("R11", 0, POLL_MAX - 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero_len();
        t_bad_id(32'h1234_5678);
        t_bad_id(32'hC208_8081);
        t_good_a();
        t_no_done();
        t_timeout();
        t_last_try();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule